// File: doc/BRIEF.md
# Chained Scatter-Gather List Builder

This block turns the bus addresses of the pages behind a user buffer into a chained scatter-gather descriptor list. After a `start` pulse it latches the list base address, the byte offset into the first page, the transfer size and two optional substitute buffers. One substitute stands in for a partial first page and the other for a partial last page. It then pulls one page address per accepted handshake and issues descriptor write transactions (slot index, 64-bit target, 32-bit length, 32-bit flags) to the memory that holds the list. Byte ordering in that memory is handled by the writer downstream.

Descriptors are grouped in blocks of eight slots, one block per 128 bytes of list memory. Slot 0 of every block is a link to the next block. Pages that follow each other physically are folded into one data entry, by rewriting that entry with a longer length. When the last page has been taken, a fixup pass shifts the entries of the final block up one slot over its link and writes a terminator. The pass reads those entries from an internal two-block shadow, so nothing is read back from memory.

Top module: `sgl_builder`

## Requirements
- R1: After reset `page_rdy`, `wr_vld` and `done` are low, and they stay low until `start` is seen.
- R2: Every block n that is opened gets a link entry written at index 8*n with target base+128*(n+1), length 128 and flags 3. The entry is written even when it is later discarded. Index = 8*block + slot.
- R3: Each page maps min(remaining size, page size - offset) bytes. The offset is the first-page offset for page 0 and zero for every later page. Data entries carry flags 1.
- R4: With a first-page substitute, page 0 targets substitute+offset. With a last-page substitute, the final page targets that address and the first-page rule wins when there is one page. Otherwise the target is the listed page address plus offset.
- R5: A page whose target equals the end address (target+length) of the latest data entry extends that entry: the same index is rewritten with the summed length and no new entry is opened.
- R6: Once a block holds 7 data entries and pages remain, the next block is opened (link written, then data from slot 1).
- R7: At completion, the data entries of the final block appear at slots 0..c-1 of that block, and a terminator with target 0, length 0 and flags 2 appears at slot c. Earlier blocks keep their link and 7 data entries.
- R8: If merging leaves the newest block with only its link, the fixup applies to the block before it: its 7 entries move to slots 0..6 and the terminator goes to slot 7.
- R9: Exactly ceil((offset+size)/page size) pages are accepted, and `page_rdy` is low when `done` is high and afterwards.
- R10: `done` is a one-cycle pulse issued together with the terminator write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a list build (accepted when idle) |
| list_base | input | 64 | Bus address of the list memory |
| first_offs | input | OFFS_W | Byte offset of the buffer within its first page |
| xfer_size | input | 32 | Total transfer size in bytes (non-zero) |
| head_sub_vld | input | 1 | First-page substitute buffer present |
| head_sub_addr | input | 64 | Address of the first-page substitute buffer |
| tail_sub_vld | input | 1 | Last-page substitute buffer present |
| tail_sub_addr | input | 64 | Address of the last-page substitute buffer |
| page_vld | input | 1 | Page address offered |
| page_addr | input | 64 | Bus address of the next page |
| page_rdy | output | 1 | Page address accepted this cycle if offered |
| wr_vld | output | 1 | Descriptor write valid |
| wr_idx | output | IDX_W | Descriptor slot index (8*block+slot) |
| wr_addr | output | 64 | Descriptor target address |
| wr_len | output | 32 | Descriptor length |
| wr_flags | output | 32 | Descriptor flags |
| done | output | 1 | List complete |

## Verification
The bench builds the block with a 256-byte page and room for 40 pages. With the small page, transfers of one to fifteen pages can cross several blocks in a few hundred cycles. They reach a block that ends on its seventh data entry, a second block, a merge into the previous block after its successor's link is already written, and both substitute buffers. The reference model folds the pages into segments and derives the final list image from the segment count alone. Every write is captured into a model memory, and that memory is compared with the image after `done`.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] len;
    logic [31:0] flags;
  } sgl_desc_t;

  localparam int unsigned SGL_BLK_BYTES = 128;

  // pages touched by a transfer starting at offs within a page
  function automatic logic [31:0] sgl_page_count(input logic [31:0] offs,
                                                 input logic [31:0] size,
                                                 input logic [31:0] page);
    logic [33:0] span;
    span = {2'b0, offs} + {2'b0, size} + {2'b0, page} - 34'd1;
    return 32'(span / {2'b0, page});
  endfunction

  // bytes mapped from one page
  function automatic logic [31:0] sgl_map_len(input logic [31:0] remain,
                                              input logic [31:0] offs,
                                              input logic [31:0] page);
    logic [31:0] room;
    room = page - offs;
    return (remain < room) ? remain : room;
  endfunction

endpackage

// File: rtl/sgl_page_calc.sv
module sgl_page_calc
  import sgl_pkg::*;
#(
  parameter int unsigned PAGE_SIZE = 4096
) (
  input  logic [31:0] remain,
  input  logic [31:0] offs,
  input  logic        is_head,
  input  logic        is_tail,
  input  logic        head_sub_vld,
  input  logic [63:0] head_sub_addr,
  input  logic        tail_sub_vld,
  input  logic [63:0] tail_sub_addr,
  input  logic [63:0] page_addr,
  output logic [31:0] map_len,
  output logic [63:0] tgt_addr
);

  assign map_len = sgl_map_len(remain, offs, 32'(PAGE_SIZE));

  always_comb begin
    if (is_head && head_sub_vld)      tgt_addr = head_sub_addr + 64'(offs);
    else if (is_tail && tail_sub_vld) tgt_addr = tail_sub_addr;
    else                              tgt_addr = page_addr + 64'(offs);
  end

endmodule

// File: rtl/sgl_shadow.sv
module sgl_shadow
  import sgl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      roll,
  input  logic      wr_en,
  input  logic [2:0] wr_slot,
  input  sgl_desc_t wr_desc,
  input  logic      ext_en,
  input  logic      ext_prev,
  input  logic [2:0] ext_slot,
  input  logic [31:0] ext_len,
  input  logic      rd_prev,
  input  logic [2:0] rd_slot,
  output sgl_desc_t rd_desc,
  output sgl_desc_t ext_desc
);

  sgl_desc_t cur_q  [8];
  sgl_desc_t prev_q [8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        cur_q[i]  <= '0;
        prev_q[i] <= '0;
      end
    end else begin
      if (roll) begin
        for (int i = 0; i < 8; i++) begin
          prev_q[i] <= cur_q[i];
          cur_q[i]  <= '0;
        end
      end
      if (wr_en) cur_q[wr_slot] <= wr_desc;
      if (ext_en) begin
        if (ext_prev) prev_q[ext_slot].len <= ext_len;
        else          cur_q[ext_slot].len  <= ext_len;
      end
    end
  end

  assign rd_desc  = rd_prev  ? prev_q[rd_slot]  : cur_q[rd_slot];
  assign ext_desc = ext_prev ? prev_q[ext_slot] : cur_q[ext_slot];

endmodule

// File: rtl/sgl_builder.sv
module sgl_builder
  import sgl_pkg::*;
#(
  parameter int unsigned PAGE_SIZE  = 4096,
  parameter int unsigned MAX_PAGES  = 64,
  parameter logic [31:0] DATA_FLAG  = 32'h1,
  parameter logic [31:0] CHAIN_FLAG = 32'h3,
  parameter logic [31:0] END_FLAG   = 32'h2,
  localparam int OFFS_W   = $clog2(PAGE_SIZE),
  localparam int MAX_BLKS = MAX_PAGES / 7 + 2,
  localparam int BLK_W    = $clog2(MAX_BLKS),
  localparam int IDX_W    = BLK_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       list_base,
  input  logic [OFFS_W-1:0] first_offs,
  input  logic [31:0]       xfer_size,
  input  logic              head_sub_vld,
  input  logic [63:0]       head_sub_addr,
  input  logic              tail_sub_vld,
  input  logic [63:0]       tail_sub_addr,
  input  logic              page_vld,
  input  logic [63:0]       page_addr,
  output logic              page_rdy,
  output logic              wr_vld,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [63:0]       wr_addr,
  output logic [31:0]       wr_len,
  output logic [31:0]       wr_flags,
  output logic              done
);

  typedef enum logic [1:0] {S_IDLE, S_CHAIN, S_PAGE, S_FIX} state_t;
  state_t state_q;

  logic [63:0] base_q, prev_end_q, hsub_q, tsub_q;
  logic        hsv_q, tsv_q, have_prev_q, last_in_prev_q;
  logic [31:0] remain_q, offs_q, npages_q, pcnt_q;
  logic [BLK_W-1:0] blk_q, fix_blk_q;
  logic [3:0]  slot_q, fix_m_q, fix_k_q;
  logic [2:0]  last_slot_q;
  logic        fix_prev_q;

  logic [31:0] map_len;
  logic [63:0] tgt_addr;
  logic        is_head, is_tail;
  sgl_desc_t   rd_desc, ext_desc;

  // named internal events
  logic accept_ev, merge_ev, last_pg_ev, blk_full_ev, chain_ev;
  logic [3:0] j_after;
  logic [BLK_W-1:0] ext_blk;

  assign page_rdy    = (state_q == S_PAGE);
  assign is_head     = (pcnt_q == 32'd0);
  assign is_tail     = (pcnt_q == npages_q - 32'd1);
  assign accept_ev   = page_rdy && page_vld;
  assign merge_ev    = accept_ev && have_prev_q && (tgt_addr == prev_end_q);
  assign last_pg_ev  = accept_ev && is_tail;
  assign blk_full_ev = accept_ev && !merge_ev && (slot_q == 4'd7) && !is_tail;
  assign chain_ev    = (state_q == S_CHAIN);
  assign j_after     = merge_ev ? slot_q : slot_q + 4'd1;
  assign ext_blk     = last_in_prev_q ? blk_q - BLK_W'(1) : blk_q;

  sgl_page_calc #(.PAGE_SIZE(PAGE_SIZE)) calc_i (
    .remain(remain_q), .offs(offs_q), .is_head(is_head), .is_tail(is_tail),
    .head_sub_vld(hsv_q), .head_sub_addr(hsub_q),
    .tail_sub_vld(tsv_q), .tail_sub_addr(tsub_q),
    .page_addr(page_addr), .map_len(map_len), .tgt_addr(tgt_addr)
  );

  sgl_shadow shadow_i (
    .clk(clk), .rst_n(rst_n), .roll(chain_ev),
    .wr_en(accept_ev && !merge_ev), .wr_slot(slot_q[2:0]),
    .wr_desc('{addr: tgt_addr, len: map_len, flags: DATA_FLAG}),
    .ext_en(merge_ev), .ext_prev(last_in_prev_q), .ext_slot(last_slot_q),
    .ext_len(ext_desc.len + map_len),
    .rd_prev(fix_prev_q), .rd_slot(fix_k_q[2:0] + 3'd1),
    .rd_desc(rd_desc), .ext_desc(ext_desc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q <= '0; prev_end_q <= '0; hsub_q <= '0; tsub_q <= '0;
      hsv_q <= 1'b0; tsv_q <= 1'b0; have_prev_q <= 1'b0; last_in_prev_q <= 1'b0;
      remain_q <= '0; offs_q <= '0; npages_q <= '0; pcnt_q <= '0;
      blk_q <= '0; fix_blk_q <= '0; slot_q <= '0; fix_m_q <= '0; fix_k_q <= '0;
      last_slot_q <= '0; fix_prev_q <= 1'b0;
      wr_vld <= 1'b0; wr_idx <= '0; wr_addr <= '0; wr_len <= '0; wr_flags <= '0;
      done <= 1'b0;
    end else begin
      wr_vld <= 1'b0;
      done   <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          base_q <= list_base; hsv_q <= head_sub_vld; hsub_q <= head_sub_addr;
          tsv_q <= tail_sub_vld; tsub_q <= tail_sub_addr;
          remain_q <= xfer_size; offs_q <= 32'(first_offs);
          npages_q <= sgl_page_count(32'(first_offs), xfer_size, 32'(PAGE_SIZE));
          pcnt_q <= '0; blk_q <= '0; slot_q <= '0; have_prev_q <= 1'b0;
          state_q <= S_CHAIN;
        end
        S_CHAIN: begin
          wr_vld   <= 1'b1;
          wr_idx   <= {blk_q, 3'd0};
          wr_addr  <= base_q + ((64'(blk_q) + 64'd1) << 7);
          wr_len   <= 32'(SGL_BLK_BYTES);
          wr_flags <= CHAIN_FLAG;
          slot_q   <= 4'd1;
          last_in_prev_q <= 1'b1;
          state_q  <= S_PAGE;
        end
        S_PAGE: if (accept_ev) begin
          remain_q   <= remain_q - map_len;
          offs_q     <= '0;
          pcnt_q     <= pcnt_q + 32'd1;
          prev_end_q <= tgt_addr + 64'(map_len);
          have_prev_q <= 1'b1;
          wr_vld <= 1'b1;
          wr_flags <= DATA_FLAG;
          if (merge_ev) begin
            wr_idx  <= {ext_blk, last_slot_q};
            wr_addr <= ext_desc.addr;
            wr_len  <= ext_desc.len + map_len;
          end else begin
            wr_idx  <= {blk_q, slot_q[2:0]};
            wr_addr <= tgt_addr;
            wr_len  <= map_len;
            slot_q  <= slot_q + 4'd1;
            last_slot_q <= slot_q[2:0];
            last_in_prev_q <= 1'b0;
          end
          if (last_pg_ev) begin
            fix_prev_q <= (j_after == 4'd1);
            fix_blk_q  <= (j_after == 4'd1) ? blk_q - BLK_W'(1) : blk_q;
            fix_m_q    <= (j_after == 4'd1) ? 4'd7 : j_after - 4'd1;
            fix_k_q    <= '0;
            state_q    <= S_FIX;
          end else if (blk_full_ev) begin
            blk_q   <= blk_q + BLK_W'(1);
            state_q <= S_CHAIN;
          end
        end
        S_FIX: begin
          wr_vld <= 1'b1;
          wr_idx <= {fix_blk_q, fix_k_q[2:0]};
          if (fix_k_q < fix_m_q) begin
            wr_addr  <= rd_desc.addr;
            wr_len   <= rd_desc.len;
            wr_flags <= rd_desc.flags;
            fix_k_q  <= fix_k_q + 4'd1;
          end else begin
            wr_addr  <= '0;
            wr_len   <= '0;
            wr_flags <= END_FLAG;
            done     <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgl_builder_chk.sv
module sgl_builder_chk #(
  parameter logic [31:0] DATA_FLAG  = 32'h1,
  parameter logic [31:0] CHAIN_FLAG = 32'h3,
  parameter logic [31:0] END_FLAG   = 32'h2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        page_rdy,
  input logic        wr_vld,
  input logic [63:0] wr_addr,
  input logic [31:0] wr_len,
  input logic [31:0] wr_flags,
  input logic        done,
  input logic        merge_ev,
  input logic        blk_full_ev
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_with_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_vld && wr_flags == END_FLAG));

  // R7
  term_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_flags == END_FLAG) |-> (wr_addr == 64'd0 && wr_len == 32'd0 && done));

  // R2
  chain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_flags == CHAIN_FLAG) |-> (wr_len == 32'd128));

  // R3
  data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_flags == DATA_FLAG) |-> (wr_len != 32'd0));

  // R9
  rdy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !page_rdy);

  // R5
  merge_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_ev |=> (wr_vld && wr_flags == DATA_FLAG));

  // R6
  block_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_full_ev |=> ##1 (wr_vld && wr_flags == CHAIN_FLAG));

endmodule

bind sgl_builder sgl_builder_chk #(
  .DATA_FLAG(DATA_FLAG), .CHAIN_FLAG(CHAIN_FLAG), .END_FLAG(END_FLAG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .page_rdy(page_rdy), .wr_vld(wr_vld),
  .wr_addr(wr_addr), .wr_len(wr_len), .wr_flags(wr_flags), .done(done),
  .merge_ev(merge_ev), .blk_full_ev(blk_full_ev)
);

// File: tb/sgl_builder_tb_top.sv
module sgl_builder_tb_top;

  localparam int unsigned PG    = 256;
  localparam int unsigned MAXP  = 40;
  localparam int OFFS_W = $clog2(PG);
  localparam int IDX_W  = $clog2(MAXP / 7 + 2) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] list_base = '0;
  logic [OFFS_W-1:0] first_offs = '0;
  logic [31:0] xfer_size = '0;
  logic head_sub_vld = 1'b0, tail_sub_vld = 1'b0;
  logic [63:0] head_sub_addr = '0, tail_sub_addr = '0;
  logic page_vld = 1'b0;
  logic [63:0] page_addr = '0;
  logic page_rdy, wr_vld, done;
  logic [IDX_W-1:0] wr_idx;
  logic [63:0] wr_addr;
  logic [31:0] wr_len, wr_flags;

  always #2 clk = ~clk;

  sgl_builder #(.PAGE_SIZE(PG), .MAX_PAGES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
    .first_offs(first_offs), .xfer_size(xfer_size),
    .head_sub_vld(head_sub_vld), .head_sub_addr(head_sub_addr),
    .tail_sub_vld(tail_sub_vld), .tail_sub_addr(tail_sub_addr),
    .page_vld(page_vld), .page_addr(page_addr), .page_rdy(page_rdy),
    .wr_vld(wr_vld), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_flags(wr_flags), .done(done)
  );

  int checks = 0, errors = 0, wd = 0;
  logic [127:0] mem [int];
  longint unsigned pg_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [127:0] ent(longint unsigned a, longint unsigned l, int f);
    return {64'(a), 32'(l), 32'(f)};
  endfunction

  task automatic run_case(input string tag, input int offs, input int size,
                          input bit hsv, input longint unsigned hsa,
                          input bit tsv, input longint unsigned tsa, input bit gap);
    longint unsigned sa[$];
    longint unsigned sl[$];
    longint unsigned base = 64'h8000_0000;
    int npg, rem, o, sz, nseg, lb, c, pidx, cyc, dn;
    longint unsigned da;
    bit acc;
    // reference: fold pages into segments
    npg = (offs + size + PG - 1) / PG;
    rem = size; o = offs;
    for (int p = 0; p < npg; p++) begin
      sz = (rem < PG - o) ? rem : PG - o;
      if (p == 0 && hsv) da = hsa + o;
      else if (p == npg - 1 && tsv) da = tsa;
      else da = pg_q[p] + o;
      if (sa.size() > 0 && sa[$] + sl[$] == da) sl[$] = sl[$] + sz;
      else begin sa.push_back(da); sl.push_back(sz); end
      rem -= sz; o = 0;
    end
    nseg = sa.size();
    lb = (nseg - 1) / 7;
    c  = nseg - 7 * lb;
    // drive
    mem.delete();
    @(negedge clk);
    list_base = base; first_offs = OFFS_W'(offs); xfer_size = size;
    head_sub_vld = hsv; head_sub_addr = hsa; tail_sub_vld = tsv; tail_sub_addr = tsa;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pidx = 0; acc = 0; dn = 0; cyc = 0;
    while (dn == 0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (acc) pidx++;
      if (wr_vld) begin
        chk(wr_flags == 1 || wr_flags == 2 || wr_flags == 3, tag, "flag code",
            128'(wr_flags), 128'(1));
        mem[int'(wr_idx)] = {wr_addr, wr_len, wr_flags};
      end
      if (done) dn++;
      page_vld  = (pidx < npg) && !(gap && (cyc % 3 == 1));
      page_addr = (pidx < npg) ? pg_q[pidx] : 64'd0;
      acc = page_vld && page_rdy;
    end
    page_vld = 1'b0;
    chk(dn == 1, "R10", "done seen", 128'(dn), 128'(1));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!page_rdy && !wr_vld && !done, "R9", "quiet after done",
          128'({page_rdy, wr_vld, done}), 128'(0));
    end
    chk(pidx == npg, "R9", "pages accepted", 128'(pidx), 128'(npg));
    // compare final image
    for (int b = 0; b <= lb; b++) begin
      if (b < lb) begin
        chk(mem.exists(8*b) && mem[8*b] === ent(base + 128*(b+1), 128, 3), "R2",
            $sformatf("%s link blk %0d", tag, b), mem.exists(8*b) ? mem[8*b] : 'x,
            ent(base + 128*(b+1), 128, 3));
        for (int s = 1; s < 8; s++)
          chk(mem.exists(8*b+s) && mem[8*b+s] === ent(sa[7*b+s-1], sl[7*b+s-1], 1),
              tag, $sformatf("data idx %0d", 8*b+s), mem.exists(8*b+s) ? mem[8*b+s] : 'x,
              ent(sa[7*b+s-1], sl[7*b+s-1], 1));
      end else begin
        for (int s = 0; s < c; s++)
          chk(mem.exists(8*b+s) && mem[8*b+s] === ent(sa[7*b+s], sl[7*b+s], 1),
              tag, $sformatf("R7 shifted idx %0d", 8*b+s), mem.exists(8*b+s) ? mem[8*b+s] : 'x,
              ent(sa[7*b+s], sl[7*b+s], 1));
        chk(mem.exists(8*b+c) && mem[8*b+c] === ent(0, 0, 2), "R7",
            $sformatf("%s terminator idx %0d", tag, 8*b+c), mem.exists(8*b+c) ? mem[8*b+c] : 'x,
            ent(0, 0, 2));
      end
    end
  endtask

  task automatic pages_apart(input int n, input longint unsigned start_a);
    pg_q.delete();
    for (int i = 0; i < n; i++) pg_q.push_back(start_a + 64'h1000 * i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!page_rdy && !wr_vld && !done, "R1", "outputs in reset",
        128'({page_rdy, wr_vld, done}), 128'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!page_rdy && !wr_vld && !done, "R1", "idle without start",
        128'({page_rdy, wr_vld, done}), 128'(0));

    // R3: single partial page
    pages_apart(1, 64'h10000);
    run_case("R3", 64, 100, 0, 0, 0, 0, 0);
    // R3: offset then three scattered pages
    pages_apart(3, 64'h20000);
    run_case("R3", 128, 600, 0, 0, 0, 0, 0);
    // R5: fully contiguous pages fold into one entry
    pg_q.delete();
    for (int i = 0; i < 5; i++) pg_q.push_back(64'h50000 + PG * i);
    run_case("R5", 16, 1100, 0, 0, 0, 0, 0);
    // R6: exactly seven entries fill the first block
    pages_apart(7, 64'h100000);
    run_case("R6", 0, 7 * PG, 0, 0, 0, 0, 0);
    // R6: second block, throttled pages
    pages_apart(10, 64'h200000);
    run_case("R6", 0, 10 * PG - 5, 0, 0, 0, 0, 1);
    // R8: last page merges after next link is written
    pages_apart(7, 64'h300000);
    pg_q.push_back(pg_q[6] + PG);
    run_case("R8", 0, 8 * PG, 0, 0, 0, 0, 0);
    // R8: same over two full blocks
    pages_apart(14, 64'h400000);
    pg_q.push_back(pg_q[13] + PG);
    run_case("R8", 0, 15 * PG, 0, 0, 0, 0, 1);
    // R4: both substitute buffers
    pages_apart(5, 64'h500000);
    run_case("R4", 32, 4 * PG, 1, 64'h900000, 1, 64'hA00000, 0);
    // R4: single page with both substitutes, head rule wins
    pages_apart(1, 64'h600000);
    run_case("R4", 8, 50, 1, 64'hB00000, 1, 64'hC00000, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule